// File: doc/BRIEF.md
# Ordered Rail Power Sequencer

This block brings up and tears down a group of supply rails in a fixed order for a host processor. It also moves those rails between a full-power state and a low-power standby state. The rails are enabled one at a time. A rail is enabled only after the rail before it reports power-good and a fixed gap has passed. After the last rail is good, a settle period passes and then the processor reset is released. When the host drops its on-request and keeps it low through a debounce window, the reset is pulled low and the rails are shut off from the top down, one every fixed interval.

While the block is running, the host can raise a standby request. A chosen subset of rails then drops to a low-voltage setting or switches off, as set by a per-rail configuration bit. All other rails stay untouched. A readiness flag from the always-on controller acts as a master gate. When it drops, every rail and the reset are cleared on the next clock edge and the ordered shutdown is skipped.

If a rail fails to report power-good within a timeout, a fault flag is set and the normal ordered shutdown runs. The fault blocks any new power-up until the on-request goes low. All delays are counted in ticks of TICK_DIV clock cycles. The on-request and standby-request inputs pass through a two-stage synchronizer. The other inputs are taken as synchronous to the clock.

Top module: `rail_sequencer`

## Requirements
- R1: After reset all rail enables, all low-voltage selects, the processor reset output and the fault flag are 0, and mode_o reads 0. Mode codes are: 0 hold, 1 ramp-up, 2 active, 3 standby, 4 ramp-down.
- R2: In hold, with readiness high and fault clear, a high on-request moves mode to 1. Rail 0 is enabled T_ON ticks after entering mode 1.
- R3: During ramp-up, rails are enabled in index order 0 to N_RAILS-1, so the enable vector is always a run of ones from bit 0. Rail k+1 is enabled T_GAP ticks after the cycle in which rail k reports power-good.
- R4: T_RST ticks after the last rail reports power-good, host_rst_n_o goes high and mode becomes 2. The reset output is high only in modes 2 and 3.
- R5: In mode 2 or 3, an on-request held low for T_DEB ticks after synchronization moves mode to 4, and host_rst_n_o goes low in that same cycle. A shorter low pulse has no effect.
- R6: On entering mode 4, the highest-indexed rail is disabled immediately. Each lower rail is disabled T_DN ticks after the one above it. No rail is enabled during mode 4. When rail 0 is disabled, mode returns to 0 in the same cycle.
- R7: In mode 2, a high standby request enters mode 3. For each rail marked in STBY_RAILS (default rails 0 and 4), a configuration bit of 1 turns the rail off, and a bit of 0 keeps it on and sets its bit in lowv_sel_o. All other rails and the reset output are unchanged. lowv_sel_o is nonzero only in mode 3 and only on rails in STBY_RAILS.
- R8: In mode 3, a low standby request returns mode to 2 with every rail enabled and lowv_sel_o cleared.
- R9: If the rail just enabled does not report power-good within T_PGTO ticks, fault_o is set and mode becomes 4. That rail is disabled at once, and the rails below it follow at T_DN intervals.
- R10: While fault_o is set, the block stays in hold with all rails off even if the on-request is high. fault_o clears when the on-request is seen low in hold.
- R11: When readiness is low, the next clock edge clears all rail enables, the low-voltage selects and the reset output, and sets mode to 0. No power-up starts while readiness is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| aon_ready_i | input | 1 | Readiness from always-on controller, synchronous |
| pwr_on_i | input | 1 | On-request from host, synchronized inside |
| sleep_req_i | input | 1 | Standby request from host, synchronized inside |
| stby_off_cfg_i | input | N_RAILS | Per-rail: 1 = off in standby, 0 = low voltage in standby |
| pgood_i | input | N_RAILS | Per-rail power-good flags |
| rail_en_o | output | N_RAILS | Per-rail enable |
| lowv_sel_o | output | N_RAILS | Per-rail low-voltage select (standby only) |
| host_rst_n_o | output | 1 | Active-low processor reset |
| mode_o | output | 3 | Current mode code |
| fault_o | output | 1 | Power-good timeout fault, latched |

## Verification
A wrong rail index or sequence state appears on rail_en_o within one gap or spacing interval. It shows as an out-of-order enable, a hole in the ramp-up enable run, or a rail turning on during ramp-down. A wrong delay count shows as a measurable shift in the cycle where the next enable, the reset release or the fault flag appears. A broken standby or readiness path shows on mode_o, lowv_sel_o and host_rst_n_o within a few cycles of the request, because each of those outputs is registered one edge after the decision.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

    typedef enum logic [2:0] {
        MODE_HOLD    = 3'd0,
        MODE_RAMP_UP = 3'd1,
        MODE_ACTIVE  = 3'd2,
        MODE_LOWPWR  = 3'd3,
        MODE_RAMP_DN = 3'd4
    } mode_e;

    typedef enum logic [2:0] {
        ST_HOLD    = 3'd0,
        ST_UP_WAIT = 3'd1,
        ST_UP_PG   = 3'd2,
        ST_UP_RST  = 3'd3,
        ST_ACTIVE  = 3'd4,
        ST_LOWPWR  = 3'd5,
        ST_DN      = 3'd6
    } state_e;

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic mode_e mode_of(input state_e s);
        case (s)
            ST_HOLD:                           return MODE_HOLD;
            ST_UP_WAIT, ST_UP_PG, ST_UP_RST:   return MODE_RAMP_UP;
            ST_ACTIVE:                         return MODE_ACTIVE;
            ST_LOWPWR:                         return MODE_LOWPWR;
            default:                           return MODE_RAMP_DN;
        endcase
    endfunction

endpackage

// File: rtl/sync_bits.sv
module sync_bits #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stg_q[g] <= '0;
                else         stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int TICK_DIV = 250,
    parameter int CNT_W    = 13
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] ticks_i,
    output logic             expire_o
);
    localparam int SUB_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICK_DIV - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] ticks;
        logic [SUB_W-1:0] sub;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d      = t_q;
        expire_o = t_q.busy && (t_q.sub == SUB_LAST) && (t_q.ticks == CNT_W'(1));
        if (load_i) begin
            t_d.busy  = 1'b1;
            t_d.ticks = ticks_i;
            t_d.sub   = '0;
        end else if (t_q.busy) begin
            if (t_q.sub == SUB_LAST) begin
                t_d.sub = '0;
                if (t_q.ticks == CNT_W'(1)) t_d.busy  = 1'b0;
                else                        t_d.ticks = t_q.ticks - CNT_W'(1);
            end else begin
                t_d.sub = t_q.sub + SUB_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) t_q <= '0;
        else         t_q <= t_d;
    end
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
    import rseq_pkg::*;
#(
    parameter int                 N_RAILS    = 7,
    parameter logic [N_RAILS-1:0] STBY_RAILS = 'b0010001,
    parameter int                 TICK_DIV   = 250,
    parameter int                 T_ON       = 2000,
    parameter int                 T_GAP      = 200,
    parameter int                 T_RST      = 2000,
    parameter int                 T_DEB      = 12,
    parameter int                 T_DN       = 800,
    parameter int                 T_PGTO     = 5000
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               aon_ready_i,
    input  logic               pwr_on_i,
    input  logic               sleep_req_i,
    input  logic [N_RAILS-1:0] stby_off_cfg_i,
    input  logic [N_RAILS-1:0] pgood_i,
    output logic [N_RAILS-1:0] rail_en_o,
    output logic [N_RAILS-1:0] lowv_sel_o,
    output logic               host_rst_n_o,
    output logic [2:0]         mode_o,
    output logic               fault_o
);
    localparam int IDX_W = (N_RAILS > 1) ? $clog2(N_RAILS) : 1;
    localparam int T_MAX = max_i(max_i(max_i(T_ON, T_GAP), max_i(T_RST, T_DEB)),
                                 max_i(T_DN, T_PGTO));
    localparam int CNT_W = $clog2(T_MAX + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_RAILS - 1);

    typedef struct packed {
        state_e             st;
        logic [IDX_W-1:0]   idx;
        logic [N_RAILS-1:0] en;
        logic [N_RAILS-1:0] lowv;
        logic               rst_n;
        logic               fault;
    } regs_t;

    localparam regs_t RST_VAL = '{st: ST_HOLD, idx: '0, en: '0, lowv: '0,
                                  rst_n: 1'b0, fault: 1'b0};

    regs_t r_d, r_q;

    // synchronized host requests
    logic [1:0] req_s;
    logic       on_s, sleep_s;

    sync_bits #(.W(2), .STAGES(2)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({sleep_req_i, pwr_on_i}),
        .q_o    (req_s)
    );
    assign on_s    = req_s[0];
    assign sleep_s = req_s[1];

    // sequence timer
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_ticks;
    logic             tmr_exp;

    tick_timer #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) i_seq_tmr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (tmr_load),
        .ticks_i  (tmr_ticks),
        .expire_o (tmr_exp)
    );

    // release debounce: held in reload unless running and request low
    logic running, deb_load, deb_exp, deb_fire;
    assign running  = (r_q.st == ST_ACTIVE) || (r_q.st == ST_LOWPWR);
    assign deb_load = on_s || !running;

    tick_timer #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) i_deb_tmr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (deb_load),
        .ticks_i  (CNT_W'(T_DEB)),
        .expire_o (deb_exp)
    );
    assign deb_fire = deb_exp && !on_s;

    logic             dn_go;
    logic [IDX_W-1:0] dn_from;

    always_comb begin
        r_d       = r_q;
        tmr_load  = 1'b0;
        tmr_ticks = '0;
        dn_go     = 1'b0;
        dn_from   = LAST;

        case (r_q.st)
            ST_HOLD: begin
                r_d.en    = '0;
                r_d.lowv  = '0;
                r_d.rst_n = 1'b0;
                if (!on_s) begin
                    r_d.fault = 1'b0;
                end else if (!r_q.fault) begin
                    r_d.st    = ST_UP_WAIT;
                    r_d.idx   = '0;
                    tmr_load  = 1'b1;
                    tmr_ticks = CNT_W'(T_ON);
                end
            end
            ST_UP_WAIT: begin
                if (tmr_exp) begin
                    r_d.en[r_q.idx] = 1'b1;
                    r_d.st          = ST_UP_PG;
                    tmr_load        = 1'b1;
                    tmr_ticks       = CNT_W'(T_PGTO);
                end
            end
            ST_UP_PG: begin
                if (pgood_i[r_q.idx]) begin
                    tmr_load = 1'b1;
                    if (r_q.idx == LAST) begin
                        r_d.st    = ST_UP_RST;
                        tmr_ticks = CNT_W'(T_RST);
                    end else begin
                        r_d.idx   = r_q.idx + IDX_W'(1);
                        r_d.st    = ST_UP_WAIT;
                        tmr_ticks = CNT_W'(T_GAP);
                    end
                end else if (tmr_exp) begin
                    r_d.fault = 1'b1;
                    dn_go     = 1'b1;
                    dn_from   = r_q.idx;
                end
            end
            ST_UP_RST: begin
                if (tmr_exp) begin
                    r_d.st    = ST_ACTIVE;
                    r_d.rst_n = 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (deb_fire) begin
                    dn_go = 1'b1;
                end else if (sleep_s) begin
                    r_d.st = ST_LOWPWR;
                    for (int i = 0; i < N_RAILS; i++) begin
                        if (STBY_RAILS[i]) begin
                            if (stby_off_cfg_i[i]) r_d.en[i]   = 1'b0;
                            else                   r_d.lowv[i] = 1'b1;
                        end
                    end
                end
            end
            ST_LOWPWR: begin
                if (deb_fire) begin
                    dn_go = 1'b1;
                end else if (!sleep_s) begin
                    r_d.st   = ST_ACTIVE;
                    r_d.en   = '1;
                    r_d.lowv = '0;
                end
            end
            ST_DN: begin
                if (tmr_exp) begin
                    r_d.en[r_q.idx] = 1'b0;
                    if (r_q.idx == '0) begin
                        r_d.st = ST_HOLD;
                    end else begin
                        r_d.idx   = r_q.idx - IDX_W'(1);
                        tmr_load  = 1'b1;
                        tmr_ticks = CNT_W'(T_DN);
                    end
                end
            end
            default: r_d = RST_VAL;
        endcase

        // ordered shutdown entry: top rail off now, next one after spacing
        if (dn_go) begin
            r_d.rst_n       = 1'b0;
            r_d.lowv        = '0;
            r_d.en[dn_from] = 1'b0;
            if (dn_from == '0) begin
                r_d.st = ST_HOLD;
            end else begin
                r_d.st    = ST_DN;
                r_d.idx   = dn_from - IDX_W'(1);
                tmr_load  = 1'b1;
                tmr_ticks = CNT_W'(T_DN);
            end
        end

        // loss of readiness overrides everything
        if (!aon_ready_i) begin
            r_d.st    = ST_HOLD;
            r_d.idx   = '0;
            r_d.en    = '0;
            r_d.lowv  = '0;
            r_d.rst_n = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= RST_VAL;
        else         r_q <= r_d;
    end

    assign rail_en_o    = r_q.en;
    assign lowv_sel_o   = r_q.lowv;
    assign host_rst_n_o = r_q.rst_n;
    assign mode_o       = mode_of(r_q.st);
    assign fault_o      = r_q.fault;
endmodule

// File: rtl/rseq_checker.sv
module rseq_checker #(
    parameter int                 N_RAILS    = 7,
    parameter logic [N_RAILS-1:0] STBY_RAILS = 'b0010001
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               aon_ready_i,
    input logic [N_RAILS-1:0] rail_en_o,
    input logic [N_RAILS-1:0] lowv_sel_o,
    input logic               host_rst_n_o,
    input logic [2:0]         mode_o,
    input logic               fault_o
);
    p_mode_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_o <= 3'd4);

    p_ramp_thermo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd1) |-> ((rail_en_o & (rail_en_o + 1'b1)) == '0));

    p_rst_when_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        host_rst_n_o |-> (mode_o == 3'd2 || mode_o == 3'd3));

    p_dn_no_enable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd4) |=> (mode_o != 3'd4 || (rail_en_o & ~$past(rail_en_o)) == '0));

    p_hold_dark_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd0) |-> (rail_en_o == '0 && lowv_sel_o == '0));

    p_lowv_standby_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lowv_sel_o != '0) |-> (mode_o == 3'd3 && (lowv_sel_o & ~STBY_RAILS) == '0));

    p_fault_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fault_o) |-> (mode_o == 3'd4 || mode_o == 3'd0));

    p_aon_drop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !aon_ready_i |=> (rail_en_o == '0 && !host_rst_n_o && mode_o == 3'd0));
endmodule

bind rail_sequencer rseq_checker #(.N_RAILS(N_RAILS), .STBY_RAILS(STBY_RAILS)) i_rseq_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .aon_ready_i  (aon_ready_i),
    .rail_en_o    (rail_en_o),
    .lowv_sel_o   (lowv_sel_o),
    .host_rst_n_o (host_rst_n_o),
    .mode_o       (mode_o),
    .fault_o      (fault_o)
);

// File: tb/test_rail_sequencer.sv
`timescale 1ns/1ps
module test_rail_sequencer;
    localparam int N    = 7;
    localparam int DIV  = 4;
    localparam int TON  = 5, TGAP = 2, TRST = 5, TDEB = 3, TDN = 4, TPGTO = 10;
    localparam int PG_LAT = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         aon = 1'b0;
    logic         pwr_on = 1'b0;
    logic         sleep = 1'b0;
    logic [N-1:0] cfg = '0;
    logic [N-1:0] pgood = '0;
    logic [N-1:0] pg_block = '0;
    logic [N-1:0] en, lowv;
    logic         hrst_n, fault;
    logic [2:0]   mode;

    int checks = 0;
    int errors = 0;
    int pg_cnt [N];

    always #2 clk = ~clk;

    rail_sequencer #(
        .N_RAILS(N), .TICK_DIV(DIV), .T_ON(TON), .T_GAP(TGAP), .T_RST(TRST),
        .T_DEB(TDEB), .T_DN(TDN), .T_PGTO(TPGTO)
    ) i_rail_sequencer (
        .clk_i(clk), .rst_ni(rst_n), .aon_ready_i(aon), .pwr_on_i(pwr_on),
        .sleep_req_i(sleep), .stby_off_cfg_i(cfg), .pgood_i(pgood),
        .rail_en_o(en), .lowv_sel_o(lowv), .host_rst_n_o(hrst_n),
        .mode_o(mode), .fault_o(fault)
    );

    // rail model: power-good PG_LAT cycles after enable, unless blocked
    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!en[i]) begin
                pgood[i]  <= 1'b0;
                pg_cnt[i] <= 0;
            end else if (!pg_block[i]) begin
                if (pg_cnt[i] >= PG_LAT) pgood[i]  <= 1'b1;
                else                     pg_cnt[i] <= pg_cnt[i] + 1;
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_win(input string req, input int act, input int exp);
        checks++;
        if (act < exp - 2 || act > exp + 2) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_mode(input int m, output int n);
        n = 0;
        while (int'(mode) != m && n < 3000) begin @(negedge clk); n++; end
    endtask

    task automatic wait_en(input int i, input bit v, output int n);
        n = 0;
        while (en[i] != v && n < 3000) begin @(negedge clk); n++; end
    endtask

    task automatic wait_pg(input int i);
        int n = 0;
        while (!pgood[i] && n < 3000) begin @(negedge clk); n++; end
    endtask

    task automatic ramp_quiet();
        int n;
        pwr_on = 1'b1;
        wait_mode(2, n);
    endtask

    task automatic drop_quiet();
        int n;
        pwr_on = 1'b0;
        wait_mode(0, n);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 enables", int'(en), 0);
        chk("R1 lowv", int'(lowv), 0);
        chk("R1 reset out", int'(hrst_n), 0);
        chk("R1 mode", int'(mode), 0);
        chk("R1 fault", int'(fault), 0);
    endtask

    task automatic t_powerup();
        int n;
        pwr_on = 1'b1;
        wait_mode(1, n);
        chk_win("R2 start latency", n, 3);
        wait_en(0, 1'b1, n);
        chk_win("R2 first rail delay", n, TON * DIV);
        for (int i = 0; i < N - 1; i++) begin
            wait_pg(i);
            wait_en(i + 1, 1'b1, n);
            chk_win("R3 gap after power-good", n, TGAP * DIV + 1);
            chk("R3 enable order", int'(en), (1 << (i + 2)) - 1);
        end
        wait_pg(N - 1);
        n = 0;
        while (!hrst_n && n < 3000) begin @(negedge clk); n++; end
        chk_win("R4 reset release delay", n, TRST * DIV + 1);
        chk("R4 active mode", int'(mode), 2);
    endtask

    task automatic t_glitch();
        pwr_on = 1'b0;
        repeat (4) @(negedge clk);
        pwr_on = 1'b1;
        repeat (40) @(negedge clk);
        chk("R5 short low ignored mode", int'(mode), 2);
        chk("R5 short low ignored reset", int'(hrst_n), 1);
    endtask

    task automatic t_standby();
        int n;
        cfg   = 7'b0000001;
        sleep = 1'b1;
        wait_mode(3, n);
        chk("R7 rail off in standby", int'(en), 7'b1111110);
        chk("R7 low-voltage select", int'(lowv), 7'b0010000);
        chk("R7 reset unaffected", int'(hrst_n), 1);
        sleep = 1'b0;
        wait_mode(2, n);
        chk("R8 rails restored", int'(en), 7'b1111111);
        chk("R8 lowv cleared", int'(lowv), 0);
        cfg   = 7'b0000000;
        sleep = 1'b1;
        wait_mode(3, n);
        chk("R7 both low-voltage", int'(lowv), 7'b0010001);
        chk("R7 all rails on", int'(en), 7'b1111111);
        sleep = 1'b0;
        wait_mode(2, n);
        chk("R8 back to active", int'(lowv), 0);
    endtask

    task automatic t_powerdown();
        int n;
        pwr_on = 1'b0;
        wait_mode(4, n);
        chk_win("R5 debounce latency", n, 2 + TDEB * DIV);
        chk("R5 reset low at once", int'(hrst_n), 0);
        chk("R6 top rail off at entry", int'(en), 7'b0111111);
        for (int k = N - 2; k >= 0; k--) begin
            wait_en(k, 1'b0, n);
            chk_win("R6 shutdown spacing", n, TDN * DIV);
        end
        chk("R6 hold after last rail", int'(mode), 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_fault();
        int n;
        pg_block = 7'b0001000;
        pwr_on   = 1'b1;
        wait_en(3, 1'b1, n);
        n = 0;
        while (!fault && n < 3000) begin @(negedge clk); n++; end
        chk_win("R9 timeout", n, TPGTO * DIV);
        chk("R9 mode ramp-down", int'(mode), 4);
        chk("R9 failed rail off", int'(en), 7'b0000111);
        wait_mode(0, n);
        chk_win("R9 remaining shutdown", n, 3 * TDN * DIV);
        repeat (100) @(negedge clk);
        chk("R10 no retry mode", int'(mode), 0);
        chk("R10 no retry rails", int'(en), 0);
        chk("R10 fault held", int'(fault), 1);
        pwr_on   = 1'b0;
        pg_block = '0;
        repeat (5) @(negedge clk);
        chk("R10 fault cleared", int'(fault), 0);
    endtask

    task automatic t_aon();
        ramp_quiet();
        aon = 1'b0;
        @(negedge clk);
        chk("R11 rails cleared", int'(en), 0);
        chk("R11 reset cleared", int'(hrst_n), 0);
        chk("R11 mode hold", int'(mode), 0);
        repeat (50) @(negedge clk);
        chk("R11 no start without readiness", int'(mode), 0);
        pwr_on = 1'b0;
        aon    = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        aon = 1'b1;
        @(negedge clk);
        t_powerup();
        t_glitch();
        t_standby();
        t_powerdown();
        t_fault();
        t_aon();
        ramp_quiet();
        drop_quiet();
        chk("R6 clean hold", int'(en), 0);
        summary();
    end
endmodule